// File: doc/BRIEF.md
# Variable-Length Instruction Fetch and Register-Port Selector

This block is the front end of a small 64-bit processor. It holds the program counter and presents it as the address of a byte-addressed instruction memory. The memory returns the ten bytes that start at that address in the same cycle. From those bytes the block splits out the opcode and function nibbles, the two register nibbles and the 64-bit little-endian constant. It works out the instruction length and the sequential next address. It also drives the two read-port register numbers and the two write-port register numbers for the register file.

Stack instructions name the stack pointer (register 4) only by implication, and the block supplies that number on the ports. Every port that an instruction does not use carries the reserved "no register" code 15. A halt instruction freezes the counter and raises a sticky halted flag. An encoding the block does not recognise freezes the counter and raises a sticky invalid flag. Both flags stay set until reset. The counter always advances sequentially. Branch targets, execution, data memory and condition codes belong to later stages.

Top module: `insn_fetch_sel`

## Requirements
- R1: A synchronous active-high reset sets the counter to RESET_PC (default 0) and clears the halted and invalid flags.
- R2: `icode` is bits 7:4 and `ifun` is bits 3:0 of the byte at the counter (byte 0, which is `imem_data[7:0]`). Register A is bits 7:4 and register B is bits 3:0 of byte 1.
- R3: The lengths are set by opcode. Opcodes 0x0 (halt), 0x1 (nop) and 0x9 (ret) take 1 byte. Opcodes 0x6 (ALU), 0xA (push) and 0xB (pop) take 2 bytes. Opcode 0x8 (call) takes 9 bytes. Opcodes 0x3 (load immediate) and 0x5 (load from memory) take 10 bytes. `pc_next` is the counter plus the length. An unrecognised encoding has length 0.
- R4: `const_val` is little-endian. For opcodes 0x3 and 0x5 it is bytes 2..9, and for 0x8 it is bytes 1..8, with the lowest byte least significant. For every other instruction it is zero.
- R5: While neither flag is set and the instruction is legal and not halt, the counter takes `pc_next` at each rising clock edge.
- R6: An ALU operation (opcode 0x6, function 0..3) drives src_a=rA, src_b=rB, dst_e=rB and dst_m=15.
- R7: A load immediate drives src_a=15, src_b=15, dst_e=rB and dst_m=15. A load from memory drives src_a=15, src_b=rB, dst_e=15 and dst_m=rA.
- R8: On the ports, push drives (rA,4,4,15), pop drives (4,4,4,rA), call drives (15,4,4,15) and ret drives (4,4,4,15), in the order src_a, src_b, dst_e, dst_m.
- R9: When halt is at the counter, `halted` rises after the next edge. The counter then stays at the halt address until reset.
- R10: Opcodes 0x2, 0x4, 0x7 and 0xC..0xF, and opcode 0x6 with a function above 3, are invalid. After the next edge `invalid` rises and stays set, and the counter holds.
- R11: halt, nop and any invalid encoding drive 15 on all four ports. All four ports also carry 15 while either flag is set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; the counter and flags change on the rising edge |
| rst | input | 1 | Synchronous active-high reset |
| imem_addr | output | PC_W | Program counter, used as the instruction memory address |
| imem_data | input | 8*(2+WORD_W/8) | Bytes at imem_addr and above; byte i is bits 8i+7:8i |
| icode | output | 4 | Opcode nibble |
| ifun | output | 4 | Function nibble |
| const_val | output | WORD_W | Little-endian constant of the instruction |
| pc_next | output | PC_W | Counter plus instruction length |
| src_a | output | 4 | Read port A register number |
| src_b | output | 4 | Read port B register number |
| dst_e | output | 4 | Write port E register number |
| dst_m | output | 4 | Write port M register number |
| halted | output | 1 | Sticky halt status |
| invalid | output | 1 | Sticky invalid-instruction status |

## Verification
A wrong length or a wrong counter update does not stay hidden. The address after the next edge is wrong, and every later instruction then decodes from the wrong bytes, so the error spreads into every output within one cycle. A wrong flag shows at once, because the counter stops or fails to stop and the four port numbers switch to 15 or fail to switch. The bench runs a reference model beside the design and compares every output on every cycle. It catches each of these faults at the first cycle where the state differs.

// File: rtl/ifs_pkg.sv
package ifs_pkg;
  localparam logic [3:0] OP_HALT = 4'h0;
  localparam logic [3:0] OP_NOP  = 4'h1;
  localparam logic [3:0] OP_IRM  = 4'h3;
  localparam logic [3:0] OP_MRM  = 4'h5;
  localparam logic [3:0] OP_ALU  = 4'h6;
  localparam logic [3:0] OP_CALL = 4'h8;
  localparam logic [3:0] OP_RET  = 4'h9;
  localparam logic [3:0] OP_PUSH = 4'hA;
  localparam logic [3:0] OP_POP  = 4'hB;
  localparam logic [3:0] ALU_FUN_MAX = 4'h3;
  localparam logic [3:0] REG_NONE = 4'hF;
  localparam logic [3:0] REG_SP   = 4'h4;
endpackage

// File: rtl/ifs_decode.sv
module ifs_decode
  import ifs_pkg::*;
#(
  parameter int PC_W   = 64,
  parameter int WORD_W = 64,
  localparam int CB    = WORD_W / 8,
  localparam int NB    = CB + 2
) (
  input  logic [8*NB-1:0] bytes_in,
  input  logic [PC_W-1:0] pc,
  output logic [3:0]      icode,
  output logic [3:0]      ifun,
  output logic [3:0]      ra,
  output logic [3:0]      rb,
  output logic [WORD_W-1:0] cval,
  output logic [PC_W-1:0] pc_next,
  output logic            legal
);
  logic [WORD_W-1:0] c_regform;
  logic [WORD_W-1:0] c_call;
  logic [3:0]        len;

  assign icode = bytes_in[7:4];
  assign ifun  = bytes_in[3:0];
  assign ra    = bytes_in[15:12];
  assign rb    = bytes_in[11:8];

  genvar k;
  generate
    for (k = 0; k < CB; k++) begin : g_cbyte
      assign c_regform[8*k +: 8] = bytes_in[8*(k+2) +: 8];
      assign c_call[8*k +: 8]    = bytes_in[8*(k+1) +: 8];
    end
  endgenerate

  always_comb begin
    legal = 1'b1;
    len   = 4'd0;
    cval  = '0;
    case (icode)
      OP_HALT, OP_NOP, OP_RET: len = 4'd1;
      OP_PUSH, OP_POP:         len = 4'd2;
      OP_ALU: begin
        if (ifun <= ALU_FUN_MAX) len = 4'd2;
        else legal = 1'b0;
      end
      OP_CALL: begin
        len  = 4'(CB + 1);
        cval = c_call;
      end
      OP_IRM, OP_MRM: begin
        len  = 4'(CB + 2);
        cval = c_regform;
      end
      default: legal = 1'b0;
    endcase
  end

  assign pc_next = pc + {{(PC_W-4){1'b0}}, len};

  // R3: a legal instruction always moves the sequential address forward by 1..NB
  always_comb begin
    if (legal) begin
      a_r3_len_in_range: assert ((pc_next - pc) >= 1 && (pc_next - pc) <= NB);
    end
  end
endmodule

// File: rtl/ifs_ports.sv
module ifs_ports
  import ifs_pkg::*;
(
  input  logic       clk,
  input  logic       rst,
  input  logic [3:0] icode,
  input  logic [3:0] ra,
  input  logic [3:0] rb,
  input  logic       block,
  output logic [3:0] src_a,
  output logic [3:0] src_b,
  output logic [3:0] dst_e,
  output logic [3:0] dst_m
);
  always_comb begin
    src_a = REG_NONE;
    src_b = REG_NONE;
    dst_e = REG_NONE;
    dst_m = REG_NONE;
    if (!block) begin
      case (icode)
        OP_ALU:  begin src_a = ra;     src_b = rb;     dst_e = rb;     end
        OP_IRM:  begin dst_e = rb;                                     end
        OP_MRM:  begin src_b = rb;     dst_m = ra;                     end
        OP_PUSH: begin src_a = ra;     src_b = REG_SP; dst_e = REG_SP; end
        OP_POP:  begin src_a = REG_SP; src_b = REG_SP; dst_e = REG_SP; dst_m = ra; end
        OP_CALL: begin src_b = REG_SP; dst_e = REG_SP;                 end
        OP_RET:  begin src_a = REG_SP; src_b = REG_SP; dst_e = REG_SP; end
        default: ;
      endcase
    end
  end

  // R11: a blocked slot must never name a write target
  a_r11_blocked_no_write: assert property (@(posedge clk) disable iff (rst)
    block |-> (dst_e == REG_NONE && dst_m == REG_NONE));
  // R8: stack operations always touch the stack pointer on the E write port
  a_r8_stack_writes_sp: assert property (@(posedge clk) disable iff (rst)
    (!block && (icode == OP_PUSH || icode == OP_POP || icode == OP_CALL || icode == OP_RET))
      |-> dst_e == REG_SP);
endmodule

// File: rtl/ifs_pc.sv
module ifs_pc #(
  parameter int              PC_W     = 64,
  parameter logic [PC_W-1:0] RESET_PC = '0
) (
  input  logic            clk,
  input  logic            rst,
  input  logic [PC_W-1:0] pc_next,
  input  logic            halt_now,
  input  logic            legal,
  output logic [PC_W-1:0] pc,
  output logic            halted,
  output logic            invalid
);
  always_ff @(posedge clk) begin
    if (rst) begin
      pc      <= RESET_PC;
      halted  <= 1'b0;
      invalid <= 1'b0;
    end else if (!halted && !invalid) begin
      if (halt_now)    halted  <= 1'b1;
      else if (!legal) invalid <= 1'b1;
      else             pc      <= pc_next;
    end
  end

  // R9: once halted, the counter never moves and the flag stays
  a_r9_halt_freezes: assert property (@(posedge clk) disable iff (rst)
    halted |=> ($stable(pc) && halted));
  // R10: the invalid flag is sticky and freezes the counter
  a_r10_invalid_sticky: assert property (@(posedge clk) disable iff (rst)
    invalid |=> ($stable(pc) && invalid));
  // R5: a running, legal, non-halt instruction moves the counter to its successor
  a_r5_advance: assert property (@(posedge clk) disable iff (rst)
    (!halted && !invalid && legal && !halt_now) |=> pc == $past(pc_next));
endmodule

// File: rtl/insn_fetch_sel.sv
module insn_fetch_sel
  import ifs_pkg::*;
#(
  parameter int              PC_W     = 64,
  parameter int              WORD_W   = 64,
  parameter logic [PC_W-1:0] RESET_PC = '0,
  localparam int             NB       = WORD_W / 8 + 2
) (
  input  logic              clk,
  input  logic              rst,
  output logic [PC_W-1:0]   imem_addr,
  input  logic [8*NB-1:0]   imem_data,
  output logic [3:0]        icode,
  output logic [3:0]        ifun,
  output logic [WORD_W-1:0] const_val,
  output logic [PC_W-1:0]   pc_next,
  output logic [3:0]        src_a,
  output logic [3:0]        src_b,
  output logic [3:0]        dst_e,
  output logic [3:0]        dst_m,
  output logic              halted,
  output logic              invalid
);
  logic [PC_W-1:0] pc;
  logic [3:0]      ra, rb;
  logic            legal;
  logic            halt_now;

  ifs_decode #(.PC_W(PC_W), .WORD_W(WORD_W)) u_dec (
    .bytes_in(imem_data), .pc(pc), .icode(icode), .ifun(ifun),
    .ra(ra), .rb(rb), .cval(const_val), .pc_next(pc_next), .legal(legal)
  );

  assign halt_now = legal && (icode == OP_HALT);

  ifs_pc #(.PC_W(PC_W), .RESET_PC(RESET_PC)) u_pc (
    .clk(clk), .rst(rst), .pc_next(pc_next), .halt_now(halt_now),
    .legal(legal), .pc(pc), .halted(halted), .invalid(invalid)
  );

  ifs_ports u_ports (
    .clk(clk), .rst(rst), .icode(icode), .ra(ra), .rb(rb),
    .block(halted || invalid || !legal),
    .src_a(src_a), .src_b(src_b), .dst_e(dst_e), .dst_m(dst_m)
  );

  assign imem_addr = pc;

  // R1: the cycle after reset starts clean at the reset address
  a_r1_reset_state: assert property (@(posedge clk)
    rst |=> (pc == RESET_PC && !halted && !invalid));
endmodule

// File: tb/insn_fetch_sel_bench.sv
module insn_fetch_sel_bench;
  logic clk = 1'b0;
  logic rst = 1'b1;
  always #5 clk = ~clk;

  logic [63:0] imem_addr, pc_next, const_val;
  logic [79:0] imem_data;
  logic [3:0]  icode, ifun, src_a, src_b, dst_e, dst_m;
  logic        halted, invalid;
  logic [7:0]  mem [0:63];

  insn_fetch_sel u_insn_fetch_sel (
    .clk(clk), .rst(rst), .imem_addr(imem_addr), .imem_data(imem_data),
    .icode(icode), .ifun(ifun), .const_val(const_val), .pc_next(pc_next),
    .src_a(src_a), .src_b(src_b), .dst_e(dst_e), .dst_m(dst_m),
    .halted(halted), .invalid(invalid)
  );

  always @* begin
    for (int i = 0; i < 10; i++) imem_data[8*i +: 8] = mem[(imem_addr[5:0] + 6'(i)) & 6'h3f];
  end

  int checks = 0;
  int errors = 0;
  bit done = 0;

  logic [63:0] m_pc;
  bit m_halted, m_invalid;

  task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s pc=%0d actual=%h expected=%h", tag, m_pc, act, exp);
    end
  endtask

  function automatic logic [7:0] mb(input logic [63:0] a);
    return mem[a[5:0]];
  endfunction

  task automatic step_check();
    logic [7:0] b0, b1;
    int op, fn, len;
    bit ok;
    logic [63:0] c;
    logic [3:0] sa, sb, de, dm;
    string ptag;
    b0 = mb(m_pc); b1 = mb(m_pc + 1);
    op = b0[7:4]; fn = b0[3:0];
    ok = 1; len = 0; c = 0;
    sa = 15; sb = 15; de = 15; dm = 15; ptag = "R11";
    case (op)
      0, 1:  len = 1;
      9: begin len = 1; sa = 4; sb = 4; de = 4; ptag = "R8"; end
      6: if (fn <= 3) begin len = 2; sa = b1[7:4]; sb = b1[3:0]; de = b1[3:0]; ptag = "R6"; end
         else ok = 0;
      10: begin len = 2; sa = b1[7:4]; sb = 4; de = 4; ptag = "R8"; end
      11: begin len = 2; sa = 4; sb = 4; de = 4; dm = b1[7:4]; ptag = "R8"; end
      8: begin len = 9; sb = 4; de = 4; ptag = "R8";
           for (int k = 7; k >= 0; k--) c = (c << 8) | 64'(mb(m_pc + 1 + 64'(k))); end
      3, 5: begin len = 10; ptag = "R7";
           if (op == 3) de = b1[3:0]; else begin sb = b1[3:0]; dm = b1[7:4]; end
           for (int k = 7; k >= 0; k--) c = (c << 8) | 64'(mb(m_pc + 2 + 64'(k))); end
      default: ok = 0;
    endcase
    if (!ok) ptag = "R11";
    if (m_halted || m_invalid) begin sa = 15; sb = 15; de = 15; dm = 15; ptag = "R11"; end
    chk("R5 pc", imem_addr, m_pc);
    chk("R2 icode", 64'(icode), 64'(op));
    chk("R2 ifun", 64'(ifun), 64'(fn));
    chk("R3 pc_next", pc_next, m_pc + 64'(len));
    chk("R4 const", const_val, c);
    chk({ptag, " src_a"}, 64'(src_a), 64'(sa));
    chk({ptag, " src_b"}, 64'(src_b), 64'(sb));
    chk({ptag, " dst_e"}, 64'(dst_e), 64'(de));
    chk({ptag, " dst_m"}, 64'(dst_m), 64'(dm));
    chk("R9 halted", 64'(halted), 64'(m_halted));
    chk("R10 invalid", 64'(invalid), 64'(m_invalid));
    if (!m_halted && !m_invalid) begin
      if (ok && op == 0) m_halted = 1;
      else if (!ok) m_invalid = 1;
      else m_pc = m_pc + 64'(len);
    end
  endtask

  task automatic clear_mem();
    for (int i = 0; i < 64; i++) mem[i] = 8'h10;
  endtask

  task automatic do_reset();
    rst = 1'b1;
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst = 1'b0;
    m_pc = 0; m_halted = 0; m_invalid = 0;
    chk("R1 pc", imem_addr, 64'd0);
    chk("R1 halted", 64'(halted), 64'd0);
    chk("R1 invalid", 64'(invalid), 64'd0);
  endtask

  task automatic run(input int n);
    for (int i = 0; i < n; i++) begin
      step_check();
      @(negedge clk);
    end
  endtask

  initial begin
    clear_mem();
    // program 1: every legal form, ending in halt
    mem[0] = 8'h30; mem[1] = 8'hF2;
    for (int k = 0; k < 8; k++) mem[2+k] = 8'(k + 1);
    mem[10] = 8'h50; mem[11] = 8'h01; mem[12] = 8'h08;
    for (int k = 1; k < 8; k++) mem[12+k] = 8'h00;
    mem[20] = 8'h62; mem[21] = 8'h12;
    mem[22] = 8'h10;
    mem[23] = 8'hA0; mem[24] = 8'h3F;
    mem[25] = 8'hB0; mem[26] = 8'h6F;
    mem[27] = 8'h80;
    for (int k = 0; k < 8; k++) mem[28+k] = 8'(8'hA0 + k);
    mem[36] = 8'h90;
    mem[37] = 8'h61; mem[38] = 8'hAB;
    mem[39] = 8'h00;
    do_reset();
    run(16);
    // program 2: last valid ALU function, then an out-of-range function
    clear_mem();
    mem[0] = 8'h63; mem[1] = 8'h12;
    mem[2] = 8'h64; mem[3] = 8'h12;
    do_reset();
    run(6);
    // program 3: nop, then reserved opcode 0x2
    clear_mem();
    mem[1] = 8'h20;
    do_reset();
    run(5);
    // program 4: reserved opcode 0xC at reset address
    clear_mem();
    mem[0] = 8'hC0;
    do_reset();
    run(4);
    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (5000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog expired");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule